// File: doc/BRIEF.md
# Successive-Approximation Converter Control Registers

This block is the register front end of a single 12-bit successive-approximation converter. Software reaches it over a byte-wide register bus made of an address, write data, a write strobe and registered read data. It holds a control/status register, a configuration register and a channel register. It drives a 3-bit channel select and a 3-bit gain code to the analog front end. It times a conversion in converter clock ticks and captures the 12-bit sample at the end of that conversion. Software then reads the result back as a high byte and a low byte.

Software starts a conversion by writing the control register with the enable bit and the busy bit both set. The block then holds busy high, counts 16 converter ticks, clears busy by itself and raises a sticky completion flag. A converter tick is one period of a clock derived from the system clock. The divider is programmable in the configuration register. The channel, gain and divider are captured when the conversion starts, so later writes to them do not disturb the conversion in progress.

Register map (addresses on `bus_addr`): 0 is control/status, 1 is configuration, 2 is channel, 3 is result high, 4 is result low. Any other address reads as 0.

Top module: `adc_ctrl`

## Requirements
- R1: After reset every register reads 0, busy and the completion flag are 0, and `chan_sel` and `gain_code` are 0.
- R2: Control register layout: bit 7 is enable, bit 5 is the completion flag and bit 4 is busy; the other bits read 0. A write with bits 7 and 4 both set starts a conversion. A write with bit 4 set and bit 7 clear starts nothing.
- R3: A conversion keeps busy at 1 for exactly 16*(D+1) system cycles, where D is configuration bits 7:3 captured at start. In its last cycle busy returns to 0, the completion flag becomes 1 and `sample_in` is captured as the result.
- R4: Address 3 reads {4'b0, result[11:8]} and address 4 reads result[7:0]. Read data appears one cycle after the address is presented. The result holds its value until the next conversion completes.
- R5: Configuration bits 2:0 select the gain. `gain_code` is the captured code with codes 000 to 011 passed through, 100 and 101 both driven as 100, and 110 and 111 both driven as 110. The configuration register reads back the full byte that was written.
- R6: Channel register bits 2:0 select one of 8 inputs and are driven on `chan_sel` from the start of a conversion. The channel register reads back {5'b0, channel}.
- R7: Only a control write with bit 5 at 0 clears the completion flag; a write with bit 5 at 1 leaves it unchanged. Completion in the same cycle as a clear leaves the flag set.
- R8: `chan_sel`, `gain_code` and the divider change only when a conversion starts. Writes to the channel or configuration registers during a conversion do not alter the conversion in progress.
- R9: A start request made while busy is 1 is ignored, and the running conversion keeps its original end time.
- R10: A control write with bit 7 at 0 during a conversion aborts it: busy reads 0 from the next cycle, the completion flag stays 0 and the result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| chan_sel | output | 3 | Channel select to the front end |
| gain_code | output | 3 | Normalised gain code to the front end |
| sample_in | input | 12 | Behavioural converter sample |

## Verification
The bench counts the busy cycles for several divider values. A design that counts one tick too many or too few, or that starts counting before the divider is captured, gives a count other than 16*(D+1). The bench drives the sample from the channel and gain outputs. A design that forwards mid-conversion register writes to the front end therefore returns a result from the wrong channel. The bench also sends a second start during busy, which catches a design that restarts its timing. It aborts a conversion by clearing the enable bit, which catches a design that sets the completion flag or overwrites the result on an abort. It sweeps all eight gain codes, which catches a design that drives the low bit of the upper gain codes unchanged.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int ADDR_W = 3;
  localparam int GN_W   = 3;
  localparam int CH_W   = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd1;
  localparam logic [ADDR_W-1:0] A_CHAN   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RES_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_RES_LO = 3'd4;

  localparam int CTL_EN   = 7;
  localparam int CTL_DONE = 5;
  localparam int CTL_BUSY = 4;

  // Upper gain codes do not use their lowest bit.
  function automatic logic [GN_W-1:0] gain_norm(input logic [GN_W-1:0] c);
    return c[2] ? {c[2:1], 1'b0} : c;
  endfunction
endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [RES_W-1:0]  result,
  output logic              en,
  output logic [7:0]        cfg,
  output logic [CH_W-1:0]   chan,
  output logic              start,
  output logic              abort,
  output logic              done_clr
);
  logic ctrl_wr;
  logic [7:0] rd_next;
  logic [7:0] ctrl_view;
  logic [15:0] res_ext;

  assign ctrl_wr  = bus_we && (bus_addr == A_CTRL);
  assign start    = ctrl_wr && bus_wdata[CTL_EN] && bus_wdata[CTL_BUSY] && !busy;
  assign abort    = ctrl_wr && !bus_wdata[CTL_EN] && busy;
  assign done_clr = ctrl_wr && !bus_wdata[CTL_DONE];

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      cfg  <= '0;
      chan <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_CTRL: en   <= bus_wdata[CTL_EN];
        A_CFG:  cfg  <= bus_wdata;
        A_CHAN: chan <= bus_wdata[CH_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTL_EN]   = en;
    ctrl_view[CTL_DONE] = done;
    ctrl_view[CTL_BUSY] = busy;
    res_ext = 16'(result);
    case (bus_addr)
      A_CTRL:   rd_next = ctrl_view;
      A_CFG:    rd_next = cfg;
      A_CHAN:   rd_next = 8'(chan);
      A_RES_HI: rd_next = res_ext[15:8];
      A_RES_LO: rd_next = res_ext[7:0];
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int STEPS = 16,
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic             done_clr,
  input  logic [DIV_W-1:0] div_in,
  input  logic [CH_W-1:0]  chan_in,
  input  logic [GN_W-1:0]  gain_in,
  input  logic [RES_W-1:0] sample_in,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  chan_q,
  output logic [GN_W-1:0]  gain_q
);
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  pre;
  logic [STEP_W-1:0] step;
  logic tick, finish;

  assign tick   = busy && (pre == div_q);
  assign finish = tick && (step == LAST) && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      pre    <= '0;
      step   <= '0;
      div_q  <= '0;
      chan_q <= '0;
      gain_q <= '0;
      result <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      pre    <= '0;
      step   <= '0;
      div_q  <= div_in;
      chan_q <= chan_in;
      gain_q <= gain_in;
    end else if (busy) begin
      if (tick) begin
        pre  <= '0;
        step <= step + 1'b1;
        if (finish) begin
          busy   <= 1'b0;
          result <= sample_in;
        end
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           done <= 1'b0;
    else if (finish)   done <= 1'b1;
    else if (done_clr) done <= 1'b0;
  end
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int STEPS = 16,
  parameter int DIV_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  output logic [2:0]        chan_sel,
  output logic [2:0]        gain_code,
  input  logic [RES_W-1:0]  sample_in
);
  logic             en, busy, done, start, abort, done_clr;
  logic [7:0]       cfg;
  logic [CH_W-1:0]  chan;
  logic [RES_W-1:0] result;

  adc_ctrl_regs #(.RES_W(RES_W)) regs_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .result(result), .en(en), .cfg(cfg), .chan(chan), .start(start),
    .abort(abort), .done_clr(done_clr)
  );

  adc_conv_seq #(.RES_W(RES_W), .STEPS(STEPS), .DIV_W(DIV_W)) seq_i (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .done_clr(done_clr),
    .div_in(cfg[7 -: DIV_W]), .chan_in(chan), .gain_in(gain_norm(cfg[GN_W-1:0])),
    .sample_in(sample_in), .busy(busy), .done(done), .result(result),
    .chan_q(chan_sel), .gain_q(gain_code)
  );
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             busy,
  input logic             done,
  input logic             abort,
  input logic             done_clr,
  input logic [RES_W-1:0] result,
  input logic [2:0]       chan_sel,
  input logic [2:0]       gain_code
);
  AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    busy |-> en); // R10
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(abort)) |-> done); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> $stable(result)); // R4
  AST_FRONT_END_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(chan_sel) && $stable(gain_code))); // R8
  AST_GAIN_UPPER_LSB: assert property (@(posedge clk) disable iff (rst)
    gain_code[2] |-> !gain_code[0]); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(done_clr)); // R7
endmodule

bind adc_ctrl adc_ctrl_chk #(.RES_W(RES_W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .busy(busy), .done(done), .abort(abort),
  .done_clr(done_clr), .result(result), .chan_sel(chan_sel), .gain_code(gain_code)
);

// File: tb/adc_ctrl_tb_top.sv
module adc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [2:0] chan_sel, gain_code;
  logic [11:0] sample_in;
  logic [11:0] salt = '0;
  logic [11:0] last_res = '0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] smp(input logic [2:0] ch, input logic [2:0] gn,
                                      input logic [11:0] s);
    return {gn, ch, 6'b0} ^ s;
  endfunction

  function automatic logic [2:0] gmap(input logic [2:0] c);
    case (c)
      3'b100, 3'b101: return 3'b100;
      3'b110, 3'b111: return 3'b110;
      default:        return c;
    endcase
  endfunction

  assign sample_in = smp(chan_sel, gain_code, salt);

  adc_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .chan_sel(chan_sel),
    .gain_code(gain_code), .sample_in(sample_in)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic poll(output int cnt);
    cnt = 0;
    bus_addr = 3'd0;
    @(negedge clk);
    while (bus_rdata[4] && cnt < 5000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic read_res(output logic [11:0] r);
    logic [7:0] h, l;
    rd(3'd3, h);
    rd(3'd4, l);
    chk("R4 high nibble pad", {8'h0, h[7:4]}, 16'h0);
    r = {h[3:0], l};
  endtask

  task automatic conv(input logic [2:0] ch, input logic [2:0] gn, input logic [4:0] dv);
    int cnt;
    logic [7:0] v;
    logic [11:0] r;
    wr(3'd1, {dv, gn});
    wr(3'd2, {5'b0, ch});
    wr(3'd0, 8'h90);
    chk("R6 chan_sel", {13'h0, chan_sel}, {13'h0, ch});
    chk("R5 gain_code", {13'h0, gain_code}, {13'h0, gmap(gn)});
    poll(cnt);
    chk("R3 busy cycles", 16'(cnt), 16'(STEPS * (dv + 1)));
    chk("R3 done after end", {8'h0, bus_rdata}, 16'h00A0);
    read_res(r);
    chk("R3 R4 result", {4'h0, r}, {4'h0, smp(ch, gmap(gn), salt)});
    last_res = r;
  endtask

  initial begin
    int cnt;
    logic [7:0] v;
    logic [11:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 chan_sel", {13'h0, chan_sel}, 16'h0);
    chk("R1 gain_code", {13'h0, gain_code}, 16'h0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reg reset", {8'h0, v}, 16'h0);
    end

    // R2 busy without enable starts nothing
    wr(3'd0, 8'h10);
    rd(3'd0, v);
    chk("R2 no start without enable", {8'h0, v}, 16'h0);

    // R5 config readback and gain sweep
    wr(3'd1, 8'hAD);
    rd(3'd1, v);
    chk("R5 cfg readback", {8'h0, v}, 16'h00AD);
    for (int g = 0; g < 8; g++) begin
      salt = 12'(g * 37);
      conv(3'(7 - g), 3'(g), 5'd0);
    end

    // R6 channel readback
    wr(3'd2, 8'hFD);
    rd(3'd2, v);
    chk("R6 chan readback", {8'h0, v}, 16'h0005);

    // R7 done sticky against bit5=1, clear on bit5=0
    wr(3'd0, 8'hA0);
    rd(3'd0, v);
    chk("R7 done kept", {8'h0, v}, 16'h00A0);
    wr(3'd0, 8'h80);
    rd(3'd0, v);
    chk("R7 done cleared", {8'h0, v}, 16'h0080);

    // R9 second start during busy does not restart
    salt = 12'h5A5;
    wr(3'd1, 8'h08);
    wr(3'd2, 8'h03);
    wr(3'd0, 8'h90);
    wr(3'd0, 8'h90);
    poll(cnt);
    chk("R9 start while busy ignored", 16'(cnt), 16'(2 * STEPS - 1));
    read_res(r);
    chk("R9 result", {4'h0, r}, {4'h0, smp(3'd3, 3'd0, salt)});
    last_res = r;

    // R8 mid-conversion changes have no effect
    wr(3'd1, 8'h10);
    wr(3'd2, 8'h06);
    wr(3'd0, 8'h90);
    wr(3'd1, 8'h07);
    wr(3'd2, 8'h01);
    chk("R8 chan_sel held", {13'h0, chan_sel}, 16'h6);
    chk("R8 gain_code held", {13'h0, gain_code}, 16'h0);
    poll(cnt);
    chk("R8 done", {8'h0, bus_rdata}, 16'h00A0);
    read_res(r);
    chk("R8 result from start values", {4'h0, r}, {4'h0, smp(3'd6, 3'd0, salt)});
    last_res = r;

    // R10 abort by clearing enable
    wr(3'd1, 8'h18);
    salt = 12'hFFF;
    wr(3'd0, 8'h90);
    repeat (5) @(negedge clk);
    wr(3'd0, 8'h00);
    rd(3'd0, v);
    chk("R10 abort clears busy", {8'h0, v}, 16'h0);
    repeat (120) @(negedge clk);
    rd(3'd0, v);
    chk("R10 no done after abort", {8'h0, v}, 16'h0);
    read_res(r);
    chk("R10 result kept", {4'h0, r}, {4'h0, last_res});

    // R3 R4 R5 R6 random conversions
    for (int i = 0; i < 16; i++) begin
      salt = 12'($urandom);
      conv(3'($urandom), 3'($urandom), 5'($urandom_range(0, 3)));
    end

    // R4 result holds across idle time
    repeat (50) @(negedge clk);
    read_res(r);
    chk("R4 result hold", {4'h0, r}, {4'h0, last_res});

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule